// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial-bus slave engine and in front of a nonvolatile array model. The engine hands it a start address, then a stream of data bytes. Each byte lands in a 32-slot page buffer. The offset inside the page advances with every byte and wraps at the page edge, while the page number stays fixed. The block answers every offered byte with an acknowledge or refuse decision, which the engine then drives onto the bus.

Nothing reaches the array while bytes are still arriving. When the engine reports a STOP, the block opens one timed program cycle of a fixed number of clock cycles and raises `busy_o` for that whole window. During the first 32 cycles of the window it scans the page slots in ascending order and issues one array write strobe for each slot that holds a byte. The block then clears `busy_o` by itself.

When the write-protect input is high, the top quarter of the address space is read-only. A transaction aimed there is refused at its first data byte, and it programs nothing. A restart (abort) before STOP throws away the buffered bytes.

Top module: `pwb_commit_ctrl`

## Requirements
- R1: After `load_i` opens a transaction, each accepted byte is answered one cycle later with `ack_vld_o`=1 and `ack_o`=1 (1 means acknowledge, 0 means refuse). The byte is stored at the current in-page offset (address bits [4:0]), that offset then increments by one, and address bits [12:5] stay fixed.
- R2: When more than 32 bytes arrive before STOP, the offset wraps from 31 to 0 and the newer bytes replace the older ones in the same slots.
- R3: No array write strobe (`mem_we_o`) occurs before STOP, and strobes appear only while `busy_o` is high.
- R4: A STOP after at least one accepted byte raises `busy_o` in the next cycle. `busy_o` stays high for exactly PROG_CYCLES cycles and then clears without any input.
- R5: During the program cycle, each buffered slot is written exactly once, in ascending offset order, at address {page, offset} with its latest byte. Slots that received no byte are not written.
- R6: With `wp_i`=1 at the first data byte and a start address whose bits [12:11] are 11 (0x1800 to 0x1FFF), that byte and every later byte of the transaction are refused. The following STOP starts no program cycle and produces no strobe.
- R7: With `wp_i`=0, the top quarter is written like any other page. With `wp_i`=1, a page just below 0x1800 is still written.
- R8: A transaction with a single byte produces exactly one strobe, at the loaded address.
- R9: `abort_i` before STOP discards the buffered bytes. The next STOP starts no program cycle, and a later transaction writes none of the discarded bytes.
- R10: A STOP after `load_i` with no data byte starts no program cycle.
- R11: Bytes offered while `busy_o` is high, or with no open transaction, are refused and not stored. `load_i` and `stop_i` during `busy_o` are ignored.
- R12: During reset, `busy_o`, `mem_we_o` and `ack_vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write-protect level for the top quarter |
| load_i | input | 1 | Opens a write transaction with `addr_i` |
| addr_i | input | ADDR_W | Start address (page and offset) |
| byte_vld_i | input | 1 | A data byte is offered this cycle |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP seen on the bus |
| abort_i | input | 1 | Restart seen before STOP; discard the transaction |
| ack_vld_o | output | 1 | Decision for the byte offered in the previous cycle |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| busy_o | output | 1 | Program cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |

## Verification
The assertions check four things on every cycle: strobes occur only inside the busy window, the window starts only after a STOP and has exactly PROG_CYCLES cycles, every decision follows an offered byte and is a refusal while busy, and an abort never lets the window open. The bench scenarios are the only way to show which bytes end up at which addresses. That covers wrap-around overwrite, the ascending single-pass scan, the protection boundary at 0x1800, and the disappearance of aborted bytes. The bench compares the strobe stream and the decisions against a model of slots and offsets built into the bench.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_DENY = 2'd2,
        PW_PROG = 2'd3
    } pw_state_e;

endpackage

// File: rtl/pwb_slot_store.sv
`timescale 1ns/1ps
module pwb_slot_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_vld_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              any_vld_o
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.vld = '0;
        end
        if (wr_i) begin
            s_d.vld[wr_idx_i] = 1'b1;
            s_d.dat[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_vld_o  = s_q.vld[rd_idx_i];
    assign rd_data_o = s_q.dat[rd_idx_i];
    assign any_vld_o = |s_q.vld;

endmodule

// File: rtl/pwb_cycle_timer.sv
`timescale 1ns/1ps
module pwb_cycle_timer #(
    parameter int LIMIT = 2000,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.run) begin
            if (t_q.cnt == LAST) begin
                t_d.run = 1'b0;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign run_o  = t_q.run;
    assign cnt_o  = t_q.cnt;
    assign last_o = t_q.run && (t_q.cnt == LAST);

endmodule

// File: rtl/pwb_commit_ctrl.sv
`timescale 1ns/1ps
module pwb_commit_ctrl
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              abort_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        pw_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              ack_vld;
        logic              ack;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              st_clr, st_wr, tm_start;
    logic              tm_run, tm_last;
    logic [CNT_W-1:0]  tm_cnt;
    logic              rd_vld, any_vld;
    logic [DATA_W-1:0] rd_data;
    logic              prot_page;
    logic              scan_on;

    // top quarter: the two highest address bits both set
    assign prot_page = &c_q.page[PAGE_W-1:PAGE_W-2];

    always_comb begin
        c_d         = c_q;
        c_d.ack_vld = 1'b0;
        c_d.ack     = 1'b0;
        st_clr      = 1'b0;
        st_wr       = 1'b0;
        tm_start    = 1'b0;
        unique case (c_q.st)
            PW_IDLE: begin
                if (load_i) begin
                    c_d.st   = PW_FILL;
                    c_d.page = addr_i[ADDR_W-1:OFF_W];
                    c_d.off  = addr_i[OFF_W-1:0];
                    st_clr   = 1'b1;
                end else if (byte_vld_i) begin
                    c_d.ack_vld = 1'b1;
                end
            end
            PW_FILL: begin
                if (abort_i) begin
                    c_d.st = PW_IDLE;
                    st_clr = 1'b1;
                end else if (load_i) begin
                    c_d.page = addr_i[ADDR_W-1:OFF_W];
                    c_d.off  = addr_i[OFF_W-1:0];
                    st_clr   = 1'b1;
                end else if (stop_i) begin
                    if (any_vld) begin
                        c_d.st   = PW_PROG;
                        tm_start = 1'b1;
                    end else begin
                        c_d.st = PW_IDLE;
                    end
                end else if (byte_vld_i) begin
                    c_d.ack_vld = 1'b1;
                    // protection decided once, on the first data byte
                    if (!any_vld && wp_i && prot_page) begin
                        c_d.st = PW_DENY;
                    end else begin
                        c_d.ack = 1'b1;
                        st_wr   = 1'b1;
                        c_d.off = c_q.off + 1'b1;
                    end
                end
            end
            PW_DENY: begin
                if (abort_i || stop_i) begin
                    c_d.st = PW_IDLE;
                end else if (load_i) begin
                    c_d.st   = PW_FILL;
                    c_d.page = addr_i[ADDR_W-1:OFF_W];
                    c_d.off  = addr_i[OFF_W-1:0];
                    st_clr   = 1'b1;
                end else if (byte_vld_i) begin
                    c_d.ack_vld = 1'b1;
                end
            end
            PW_PROG: begin
                if (byte_vld_i) begin
                    c_d.ack_vld = 1'b1;
                end
                if (tm_last) begin
                    c_d.st = PW_IDLE;
                    st_clr = 1'b1;
                end
            end
            default: c_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: PW_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    pwb_slot_store #(
        .DATA_W (DATA_W),
        .DEPTH  (PAGE_BYTES),
        .IDX_W  (OFF_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (st_clr),
        .wr_i      (st_wr),
        .wr_idx_i  (c_q.off),
        .wr_data_i (byte_i),
        .rd_idx_i  (tm_cnt[OFF_W-1:0]),
        .rd_vld_o  (rd_vld),
        .rd_data_o (rd_data),
        .any_vld_o (any_vld)
    );

    pwb_cycle_timer #(
        .LIMIT (PROG_CYCLES),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tm_start),
        .run_o   (tm_run),
        .cnt_o   (tm_cnt),
        .last_o  (tm_last)
    );

    // slot scan occupies the first PAGE_BYTES cycles of the program window
    assign scan_on    = tm_run && (tm_cnt < SCAN_END);
    assign mem_we_o   = scan_on && rd_vld;
    assign mem_addr_o = {c_q.page, tm_cnt[OFF_W-1:0]};
    assign mem_data_o = rd_data;
    assign busy_o     = tm_run;
    assign ack_vld_o  = c_q.ack_vld;
    assign ack_o      = c_q.ack;

endmodule

// File: rtl/pwb_commit_ctrl_chk.sv
`timescale 1ns/1ps
module pwb_commit_ctrl_chk #(
    parameter int PROG_CYCLES = 2000,
    parameter int PAGE_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld_i,
    input logic              stop_i,
    input logic              abort_i,
    input logic              ack_vld_o,
    input logic              ack_o,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [PAGE_W-1:0] mem_page
);

    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy_o) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R3: strobes only inside the program window
    a_r3_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R4: the window opens only after a STOP
    a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R4: the window closes after exactly PROG_CYCLES cycles
    a_r4_busy_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == PROG_CYCLES));

    // R4: the window never runs past PROG_CYCLES
    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len < PROG_CYCLES));

    // R1: a decision only follows an offered byte
    a_r1_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i));

    // R11: bytes offered while busy are refused
    a_r11_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_o && $past(busy_o)) |-> !ack_o);

    // R9: an abort never opens a program window
    a_r9_abort_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !busy_o) |=> !busy_o);

    // R5: back-to-back strobes of one commit stay in one page
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_page == $past(mem_page)));

endmodule

bind pwb_commit_ctrl pwb_commit_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .PAGE_W      (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld_i),
    .stop_i     (stop_i),
    .abort_i    (abort_i),
    .ack_vld_o  (ack_vld_o),
    .ack_o      (ack_o),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_page   (mem_addr_o[ADDR_W-1:OFF_W])
);

// File: tb/pwb_commit_ctrl_bench.sv
`timescale 1ns/1ps
module pwb_commit_ctrl_bench;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam int PC = 48;

    logic          clk, rst_n, wp_i, load_i, byte_vld_i, stop_i, abort_i;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] byte_i;
    logic          ack_vld_o, ack_o, busy_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_data_o;

    pwb_commit_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(32), .PROG_CYCLES(PC))
    u_pwb_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .load_i(load_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .abort_i(abort_i),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the page buffer
    bit [7:0] m_dat [32];
    bit       m_vld [32];
    int       m_page, m_off;
    bit       m_deny, m_open;

    // strobe and busy monitor
    int g_cnt, busy_cnt;
    int g_addr [64];
    int g_data [64];

    always @(negedge clk) begin
        if (mem_we_o && g_cnt < 64) begin
            g_addr[g_cnt] = int'(mem_addr_o);
            g_data[g_cnt] = int'(mem_data_o);
            g_cnt++;
        end
        if (busy_o) busy_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit prot(input int page, input bit wp);
        return wp && ((page >> 6) == 3);
    endfunction

    function automatic bit m_any();
        for (int i = 0; i < 32; i++) if (m_vld[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
    endtask

    task automatic tload(input int a);
        @(negedge clk);
        g_cnt = 0;
        load_i = 1'b1;
        addr_i = AW'(a);
        @(negedge clk);
        load_i = 1'b0;
        m_clear();
        m_page = a >> 5;
        m_off  = a & 31;
        m_deny = 1'b0;
        m_open = 1'b1;
    endtask

    task automatic tbyte(input bit [7:0] d, input string req);
        bit exp;
        if (!m_open || m_deny) begin
            exp = 1'b0;
        end else if (!m_any() && prot(m_page, wp_i)) begin
            exp = 1'b0;
            m_deny = 1'b1;
        end else begin
            exp = 1'b1;
            m_dat[m_off] = d;
            m_vld[m_off] = 1'b1;
            m_off = (m_off + 1) % 32;
        end
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i = d;
        @(negedge clk);
        byte_vld_i = 1'b0;
        chk(ack_vld_o && (ack_o == exp), req, 2 * int'(ack_vld_o) + int'(ack_o), 2 + int'(exp));
    endtask

    task automatic tabort();
        @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        m_open = 1'b0;
        m_clear();
    endtask

    // poke: offer a byte and a load while busy (R11)
    task automatic tstop(input string req, input bit poke);
        bit exp_busy;
        int k;
        exp_busy = m_open && !m_deny && m_any();
        @(negedge clk);
        chk(g_cnt == 0, "R3 no strobe before STOP", g_cnt, 0);
        g_cnt = 0;
        busy_cnt = 0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(busy_o == exp_busy, {req, " R4 busy after STOP"}, int'(busy_o), int'(exp_busy));
        if (poke) begin
            byte_vld_i = 1'b1;
            byte_i = 8'h5A;
            @(negedge clk);
            byte_vld_i = 1'b0;
            chk(ack_vld_o && !ack_o, "R11 byte refused while busy", 2 * int'(ack_vld_o) + int'(ack_o), 2);
            load_i = 1'b1;
            addr_i = 13'h0400;
            @(negedge clk);
            load_i = 1'b0;
        end
        repeat (PC + 4) @(negedge clk);
        chk(busy_cnt == (exp_busy ? PC : 0), {req, " R4 busy length"}, busy_cnt, exp_busy ? PC : 0);
        k = 0;
        if (exp_busy) begin
            for (int o = 0; o < 32; o++) begin
                if (m_vld[o]) begin
                    chk(g_addr[k] == m_page * 32 + o && g_data[k] == int'(m_dat[o]),
                        {req, " R5 strobe addr/data"}, g_addr[k] * 256 + g_data[k],
                        (m_page * 32 + o) * 256 + int'(m_dat[o]));
                    k++;
                end
            end
        end
        chk(g_cnt == k, {req, " R5 strobe count"}, g_cnt, k);
        m_open = 1'b0;
        m_clear();
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h5eed));
        rst_n = 1'b0; wp_i = 1'b0; load_i = 1'b0; addr_i = '0; byte_vld_i = 1'b0;
        byte_i = '0; stop_i = 1'b0; abort_i = 1'b0;
        g_cnt = 0; busy_cnt = 0; m_open = 1'b0; m_deny = 1'b0; m_page = 0; m_off = 0;
        m_clear();
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_we_o && !ack_vld_o, "R12 reset state",
            int'(busy_o) + int'(mem_we_o) + int'(ack_vld_o), 0);
        rst_n = 1'b1;

        // R8 single byte, R1 ACK
        tload(13'h0123);
        tbyte(8'hA7, "R1 single byte ack");
        tstop("R8 single", 1'b0);

        // R1 in-page wrap of offset, page fixed
        tload(13'h025E);
        for (int i = 0; i < 5; i++) tbyte(8'(8'h10 + i), "R1 offset wrap");
        tstop("R1 wrap commit", 1'b0);

        // R2 overflow: 40 bytes from offset 4
        tload(13'h0344);
        for (int i = 0; i < 40; i++) tbyte(8'(i * 3 + 1), "R2 overflow ack");
        chk(m_dat[4] == 8'(32 * 3 + 1), "R2 model overwrite", int'(m_dat[4]), 97);
        tstop("R2 overflow commit", 1'b0);

        // R6 protected first byte and later bytes refused
        wp_i = 1'b1;
        tload(13'h1810);
        tbyte(8'h11, "R6 first byte refused");
        tbyte(8'h22, "R6 later byte refused");
        tstop("R6 protected", 1'b0);
        tload(13'h1FFF);
        tbyte(8'h33, "R6 top address refused");
        tstop("R6 top", 1'b0);

        // R7 boundary just below protected area with wp high
        tload(13'h17FF);
        tbyte(8'h44, "R7 below boundary ack");
        tbyte(8'h45, "R7 below boundary ack wrap");
        tstop("R7 below boundary", 1'b0);

        // R7 wp low: top quarter writable
        wp_i = 1'b0;
        tload(13'h1F00);
        for (int i = 0; i < 3; i++) tbyte(8'(8'hC0 + i), "R7 wp low ack");
        tstop("R7 wp low", 1'b0);

        // R9 abort discards
        tload(13'h0A00);
        for (int i = 0; i < 3; i++) tbyte(8'(8'h70 + i), "R9 bytes before abort");
        tabort();
        tstop("R9 after abort", 1'b0);
        tload(13'h0A05);
        tbyte(8'h99, "R9 new transaction");
        tstop("R9 only new byte", 1'b0);

        // R10 address only
        tload(13'h0777);
        tstop("R10 no data", 1'b0);

        // R11 busy interference, then load during busy ignored
        tload(13'h0040);
        tbyte(8'hE1, "R11 setup");
        tstop("R11 busy poke", 1'b1);
        tbyte(8'hE2, "R11 no open transaction refused");

        // random mix
        for (int t = 0; t < 25; t++) begin
            int a, n;
            wp_i = 1'($urandom % 2);
            a = int'($urandom % 8192);
            n = 1 + int'($urandom % 40);
            tload(a);
            for (int i = 0; i < n; i++) tbyte(8'($urandom), "R1 random ack");
            if ($urandom % 6 == 0) tabort();
            tstop("R5 random", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule